// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block combines three reset sources into nested internal reset domains. The sources are an external power-on reset pin, an external manual reset pin and a watchdog overflow event. The widest domain covers the pin-function and port registers, the middle domain covers the on-chip peripherals, and the narrowest covers CPU state only.

An external power-on reset drives all three domains. A watchdog overflow drives the peripheral and CPU domains, and only when the watchdog is configured to reset. A qualified manual reset drives the CPU domain alone. The manual pin must be held low for a minimum number of clock cycles, and the manual reset begins only after any bus cycle in progress has finished.

When a reset ends, the block sends a one-cycle start request to the exception sequencer and tags it as a power-on start or a manual start. The block also keeps a sticky watchdog overflow flag and a register that records the cause of the last reset.

Top module: `reset_source_ctrl`

## Requirements
- R1: While the synchronized power-on pin is low, rst_pinmux, rst_periph and rst_cpu are all 1. reset_cause reads 0 (pin) and wdt_flag reads 0. Each output changes 3 clock edges after the pin changes. On release, all three domains drop and exc_start pulses with exc_kind=0 (power-on).
- R2: A wdt_ovf pulse with wdt_por_en=1 and no reset already running asserts rst_periph and rst_cpu for exactly WDT_HOLD cycles, starting on the sampling edge. rst_pinmux stays 0 and reset_cause becomes 1 (watchdog). The domains drop on the edge where exc_start pulses with exc_kind=0. A further overflow during this window neither restarts nor extends it.
- R3: Every sampled wdt_ovf sets wdt_flag to 1, and the flag stays set until the next power-on pin reset. With wdt_por_en=0 an overflow asserts no reset domain and raises no exc_start.
- R4: When the power-on pin and a watchdog overflow fall on the same sampling edge, the pin reset wins. wdt_flag reads 0, reset_cause reads 0, and no watchdog reset window follows the pin release.
- R5: The manual pin is ignored while the power-on pin is low. A long manual low during a power-on reset produces only the power-on start request.
- R6: A manual low shorter than MIN_LOW synchronized samples has no effect on any output.
- R7: A qualified manual reset asserts rst_cpu only, with rst_periph and rst_pinmux staying 0, and sets reset_cause to 2 (manual). If the pin is low at edge 0, rst_cpu rises after edge MIN_LOW+2.
- R8: Manual entry is held off while bus_busy is 1 and happens on the first edge that samples bus_busy=0. If the pin returns high before entry, nothing happens.
- R9: After a manual reset has been entered, the pin's return high drops rst_cpu and pulses exc_start for one cycle with exc_kind=1 (manual). This happens 3 edges after the pin rises.
- R10: exc_start is never 1 while any reset domain is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high block reset |
| por_pin_n | input | 1 | External power-on reset pin, active low, asynchronous |
| mres_pin_n | input | 1 | External manual reset pin, active low, asynchronous |
| wdt_ovf | input | 1 | Watchdog counter overflow event, one cycle |
| wdt_por_en | input | 1 | Watchdog configured to issue a power-on reset |
| bus_busy | input | 1 | A bus cycle is in progress |
| rst_pinmux | output | 1 | Reset for pin-function and port registers |
| rst_periph | output | 1 | Reset for on-chip peripheral registers |
| rst_cpu | output | 1 | Reset for CPU internal state |
| exc_start | output | 1 | One-cycle start request to the exception sequencer |
| exc_kind | output | 1 | Start kind: 0 power-on, 1 manual |
| wdt_flag | output | 1 | Sticky watchdog overflow flag |
| reset_cause | output | 2 | Last reset source: 0 pin, 1 watchdog, 2 manual |

## Verification
Pin-driven effects pass through the two synchronizer stages and one output register. A pin change driven after edge 0 therefore shows up after edge 3, and a manual reset qualifies after edge MIN_LOW+2. Watchdog effects take effect on the sampling edge, and the watchdog window closes WDT_HOLD edges later. The bench drives inputs just after an edge and samples one time unit later. For each sweep of manual low length and bus release point, it computes the edge index at which rst_cpu and exc_start must change and compares every cycle of the window against that index.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    typedef enum logic [1:0] {
        CAUSE_PIN = 2'd0,
        CAUSE_WDT = 2'd1,
        CAUSE_MAN = 2'd2
    } cause_e;

    typedef enum logic {
        EXC_POWERON = 1'b0,
        EXC_MANUAL  = 1'b1
    } exc_kind_e;

    typedef struct packed {
        logic pinmux;
        logic periph;
        logic cpu;
    } dom_t;

    // Domains nest: a wider source always covers the narrower domains.
    function automatic dom_t dom_merge(input logic ext_on, input logic wdt_on,
                                       input logic man_on);
        dom_t d;
        d.pinmux = ext_on;
        d.periph = ext_on | wdt_on;
        d.cpu    = ext_on | wdt_on | man_on;
        return d;
    endfunction

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int   WIDTH  = 2,
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{IDLE}};
                else     chain <= {chain[STAGES-2:0], d[i]};
            end
            assign q[i] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/rstc_mres_qual.sv
module rstc_mres_qual #(
    parameter int MIN_LOW = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic mres_low,
    input  logic kill,
    input  logic bus_busy,
    output logic man_active,
    output logic man_enter,
    output logic man_done
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] ENTRY_AT = CW'(MIN_LOW - 1);
    localparam logic [CW-1:0] SAT      = CW'(MIN_LOW);

    logic [CW-1:0] low_cnt;
    logic          active_q;

    assign man_enter  = !active_q && mres_low && !kill && !bus_busy
                        && (low_cnt >= ENTRY_AT);
    assign man_done   = active_q && !mres_low && !kill;
    assign man_active = active_q;

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            low_cnt  <= '0;
            active_q <= 1'b0;
        end else begin
            if (!mres_low)           low_cnt <= '0;
            else if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
            if (man_enter)     active_q <= 1'b1;
            else if (man_done) active_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rstc_wdt_stretch.sv
module rstc_wdt_stretch #(
    parameter int HOLD = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    input  logic kill,
    output logic active,
    output logic start,
    output logic done
);
    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] LOAD = CW'(HOLD - 1);

    logic [CW-1:0] cnt;
    logic          active_q;

    assign start  = start_req && !active_q && !kill;
    assign done   = active_q && (cnt == '0) && !kill;
    assign active = active_q;

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            active_q <= 1'b0;
            cnt      <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt      <= LOAD;
        end else if (active_q) begin
            if (cnt == '0) active_q <= 1'b0;
            else           cnt      <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/reset_source_ctrl.sv
module reset_source_ctrl
    import rstc_pkg::*;
#(
    parameter int MIN_LOW     = 20,
    parameter int WDT_HOLD    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       por_pin_n,
    input  logic       mres_pin_n,
    input  logic       wdt_ovf,
    input  logic       wdt_por_en,
    input  logic       bus_busy,
    output logic       rst_pinmux,
    output logic       rst_periph,
    output logic       rst_cpu,
    output logic       exc_start,
    output logic       exc_kind,
    output logic       wdt_flag,
    output logic [1:0] reset_cause
);
    logic [1:0] pins_s;
    logic       por_low, mres_low;
    logic       por_q, por_done;
    logic       wdt_active, wdt_start, wdt_done;
    logic       man_active, man_enter, man_done, man_kill;
    logic       exc_q, flag_q;
    exc_kind_e  kind_q;
    cause_e     cause_q;
    dom_t       doms;

    rstc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({mres_pin_n, por_pin_n}),
        .q   (pins_s)
    );

    assign por_low  = !pins_s[0];
    assign mres_low = !pins_s[1];
    assign por_done = por_q && !por_low;

    rstc_wdt_stretch #(.HOLD(WDT_HOLD)) u_wdt (
        .clk       (clk),
        .rst       (rst),
        .start_req (wdt_ovf && wdt_por_en),
        .kill      (por_low),
        .active    (wdt_active),
        .start     (wdt_start),
        .done      (wdt_done)
    );

    // Both power-on style resets override a manual reset in any phase.
    assign man_kill = por_low || wdt_active || wdt_start;

    rstc_mres_qual #(.MIN_LOW(MIN_LOW)) u_mres (
        .clk        (clk),
        .rst        (rst),
        .mres_low   (mres_low),
        .kill       (man_kill),
        .bus_busy   (bus_busy),
        .man_active (man_active),
        .man_enter  (man_enter),
        .man_done   (man_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            por_q   <= 1'b0;
            exc_q   <= 1'b0;
            kind_q  <= EXC_POWERON;
            flag_q  <= 1'b0;
            cause_q <= CAUSE_PIN;
        end else begin
            por_q <= por_low;
            exc_q <= (por_done || wdt_done || man_done) && !wdt_start;
            if (man_done)                kind_q <= EXC_MANUAL;
            else if (por_done || wdt_done) kind_q <= EXC_POWERON;
            if (por_low)      flag_q <= 1'b0;
            else if (wdt_ovf) flag_q <= 1'b1;
            if (por_low)        cause_q <= CAUSE_PIN;
            else if (wdt_start) cause_q <= CAUSE_WDT;
            else if (man_enter) cause_q <= CAUSE_MAN;
        end
    end

    assign doms        = dom_merge(por_q, wdt_active, man_active);
    assign rst_pinmux  = doms.pinmux;
    assign rst_periph  = doms.periph;
    assign rst_cpu     = doms.cpu;
    assign exc_start   = exc_q;
    assign exc_kind    = kind_q;
    assign wdt_flag    = flag_q;
    assign reset_cause = cause_q;
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker (
    input logic       clk,
    input logic       rst,
    input logic       bus_busy,
    input logic       rst_pinmux,
    input logic       rst_periph,
    input logic       rst_cpu,
    input logic       exc_start,
    input logic       exc_kind,
    input logic       wdt_flag,
    input logic [1:0] reset_cause
);
    assert_pinmux_nest_R7: assert property (@(posedge clk) disable iff (rst)
        rst_pinmux |-> rst_periph);

    assert_periph_nest_R7: assert property (@(posedge clk) disable iff (rst)
        rst_periph |-> rst_cpu);

    assert_pin_clears_R4: assert property (@(posedge clk) disable iff (rst)
        rst_pinmux |-> (!wdt_flag && reset_cause == 2'd0));

    assert_wdt_cause_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(rst_periph) && !rst_pinmux) |-> reset_cause == 2'd1);

    assert_bus_idle_entry_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(rst_cpu) && !rst_periph) |-> !$past(bus_busy));

    assert_exc_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        exc_start |=> !exc_start);

    assert_manual_origin_R9: assert property (@(posedge clk) disable iff (rst)
        (exc_start && exc_kind) |-> ($past(rst_cpu) && !$past(rst_periph)));

    assert_exc_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        exc_start |-> !rst_cpu);
endmodule

bind reset_source_ctrl rstc_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_busy    (bus_busy),
    .rst_pinmux  (rst_pinmux),
    .rst_periph  (rst_periph),
    .rst_cpu     (rst_cpu),
    .exc_start   (exc_start),
    .exc_kind    (exc_kind),
    .wdt_flag    (wdt_flag),
    .reset_cause (reset_cause)
);

// File: tb/reset_source_ctrl_test.sv
module reset_source_ctrl_test;
    localparam int MIN_LOW  = 20;
    localparam int WDT_HOLD = 8;

    logic clk = 1'b0;
    logic rst, por_pin_n, mres_pin_n, wdt_ovf, wdt_por_en, bus_busy;
    logic rst_pinmux, rst_periph, rst_cpu, exc_start, exc_kind, wdt_flag;
    logic [1:0] reset_cause;
    int vectors = 0;
    int fails   = 0;

    always #10 clk = ~clk;

    reset_source_ctrl #(.MIN_LOW(MIN_LOW), .WDT_HOLD(WDT_HOLD)) uut (
        .clk(clk), .rst(rst), .por_pin_n(por_pin_n), .mres_pin_n(mres_pin_n),
        .wdt_ovf(wdt_ovf), .wdt_por_en(wdt_por_en), .bus_busy(bus_busy),
        .rst_pinmux(rst_pinmux), .rst_periph(rst_periph), .rst_cpu(rst_cpu),
        .exc_start(exc_start), .exc_kind(exc_kind), .wdt_flag(wdt_flag),
        .reset_cause(reset_cause)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic man_run(input int len, input int bus_rel, input string req);
        int  entry_edge;
        bit  entered;
        entry_edge = (MIN_LOW + 2 > bus_rel + 1) ? MIN_LOW + 2 : bus_rel + 1;
        entered    = (len >= MIN_LOW) && (entry_edge <= len + 2);
        bus_busy   = (bus_rel > 0);
        mres_pin_n = 1'b0;
        for (int k = 1; k <= len + 6; k++) begin
            tick();
            chk({req, " rst_cpu"}, 32'(rst_cpu),
                32'(entered && k >= entry_edge && k <= len + 2));
            chk({req, " exc_start"}, 32'(exc_start), 32'(entered && k == len + 3));
            chk({req, " R7 periph untouched"}, 32'(rst_periph), 32'd0);
            if (entered && k == len + 3) chk("R9 exc_kind manual", 32'(exc_kind), 32'd1);
            if (k == len)     mres_pin_n = 1'b1;
            if (k == bus_rel) bus_busy   = 1'b0;
        end
        if (entered) chk("R7 cause manual", 32'(reset_cause), 32'd2);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; por_pin_n = 1'b1; mres_pin_n = 1'b1;
        wdt_ovf = 1'b0; wdt_por_en = 1'b0; bus_busy = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        // Reset state
        chk("R1 reset pinmux", 32'(rst_pinmux), 32'd0);
        chk("R1 reset cpu", 32'(rst_cpu), 32'd0);
        chk("R10 reset exc", 32'(exc_start), 32'd0);
        chk("R3 reset flag", 32'(wdt_flag), 32'd0);
        chk("R1 reset cause", 32'(reset_cause), 32'd0);

        // R1: external power-on reset
        por_pin_n = 1'b0;
        tick(); tick();
        chk("R1 not yet", 32'(rst_pinmux), 32'd0);
        tick();
        chk("R1 pinmux", 32'(rst_pinmux), 32'd1);
        chk("R1 periph", 32'(rst_periph), 32'd1);
        chk("R1 cpu", 32'(rst_cpu), 32'd1);
        chk("R1 cause", 32'(reset_cause), 32'd0);
        repeat (5) tick();
        por_pin_n = 1'b1;
        tick(); tick();
        chk("R1 still held", 32'(rst_pinmux), 32'd1);
        chk("R10 no early exc", 32'(exc_start), 32'd0);
        tick();
        chk("R1 released", 32'({rst_pinmux, rst_periph, rst_cpu}), 32'd0);
        chk("R1 exc_start", 32'(exc_start), 32'd1);
        chk("R1 exc_kind", 32'(exc_kind), 32'd0);
        tick();
        chk("R1 exc one cycle", 32'(exc_start), 32'd0);

        // R3: overflow with reset disabled
        wdt_por_en = 1'b0; wdt_ovf = 1'b1;
        tick();
        wdt_ovf = 1'b0;
        chk("R3 flag set", 32'(wdt_flag), 32'd1);
        for (int k = 0; k < WDT_HOLD + 2; k++) begin
            chk("R3 no reset", 32'(rst_cpu), 32'd0);
            chk("R3 no exc", 32'(exc_start), 32'd0);
            tick();
        end

        // R2: watchdog power-on reset window
        wdt_por_en = 1'b1; wdt_ovf = 1'b1;
        tick();
        wdt_ovf = 1'b0;
        chk("R2 periph", 32'(rst_periph), 32'd1);
        chk("R2 cpu", 32'(rst_cpu), 32'd1);
        chk("R2 pinmux spared", 32'(rst_pinmux), 32'd0);
        chk("R2 cause", 32'(reset_cause), 32'd1);
        for (int k = 1; k <= WDT_HOLD - 1; k++) begin
            tick();
            chk("R2 window", 32'(rst_periph), 32'd1);
            chk("R2 no exc", 32'(exc_start), 32'd0);
            wdt_ovf = (k == 3);
        end
        wdt_ovf = 1'b0;
        tick();
        chk("R2 end", 32'({rst_pinmux, rst_periph, rst_cpu}), 32'd0);
        chk("R2 exc_start", 32'(exc_start), 32'd1);
        chk("R2 exc_kind", 32'(exc_kind), 32'd0);
        tick();
        chk("R2 exc one cycle", 32'(exc_start), 32'd0);
        chk("R3 flag sticky", 32'(wdt_flag), 32'd1);

        // R4: pin reset and overflow on the same edge
        por_pin_n = 1'b0;
        tick(); tick();
        wdt_ovf = 1'b1;
        tick();
        wdt_ovf = 1'b0;
        chk("R4 flag cleared", 32'(wdt_flag), 32'd0);
        chk("R4 cause pin", 32'(reset_cause), 32'd0);
        chk("R4 pinmux", 32'(rst_pinmux), 32'd1);
        repeat (2) tick();
        por_pin_n = 1'b1;
        tick(); tick(); tick();
        chk("R4 no wdt window", 32'(rst_periph), 32'd0);
        chk("R4 exc", 32'(exc_start), 32'd1);
        tick();
        wdt_por_en = 1'b0;

        // R6/R7/R9: sweep of manual low length, bus idle
        for (int len = 1; len <= MIN_LOW + 3; len++)
            man_run(len, 0, (len < MIN_LOW) ? "R6 short low" : "R7 manual");

        // R8: bus cycle holds off entry
        man_run(MIN_LOW + 10, MIN_LOW + 5, "R8 bus wait");
        man_run(MIN_LOW + 2, MIN_LOW + 6, "R8 released before entry");
        man_run(MIN_LOW, 5, "R8 early bus end");

        // R5: manual pin ignored during power-on reset
        por_pin_n = 1'b0; mres_pin_n = 1'b0;
        for (int k = 1; k <= 40; k++) begin
            tick();
            if (k == 33) chk("R5 no manual exc", 32'(exc_start), 32'd0);
            if (k == 38) begin
                chk("R5 power-on exc", 32'(exc_start), 32'd1);
                chk("R5 kind power-on", 32'(exc_kind), 32'd0);
                chk("R5 cause pin", 32'(reset_cause), 32'd0);
            end
            if (k == 30) mres_pin_n = 1'b1;
            if (k == 35) por_pin_n  = 1'b1;
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule